// File: doc/BRIEF.md
# DAC Current-Source Trim Calibration Sequencer

This block is the digital sequencer that trims the unary MSB current sources of a current-steering DAC. After a start request it walks a calibration index upward from zero. Index 0 selects the LSB reference current. Its digitised value is kept as the reference for the rest of the run. Each later index selects one MSB source. That source's measurement is compared with the scaled reference to form a signed error term.

For every MSB source the block then runs a successive-approximation search on that source's trim code, one bit per clock from MSB down to LSB. The analog side feeds back a comparator decision for each trial code. The finished code stays in a per-source register. That register drives the source's correction DAC through a flat trim bus. A separate index/read port returns any stored code. A single-cycle done pulse marks the end of the run.

Top module: `dac_trim_cal`

## Requirements
- R1: While reset is held and right after it, busy_o and done_o are 0, sel_o is 0, and every trim code equals mid-scale, which is 2^(TRIM_W-1) (32 with the default width).
- R2: A start_i pulse while idle raises busy_o on the next edge, with sel_o at 0 and meas_req_o high. A start_i that arrives while busy_o is high is ignored: sel_o does not return to 0 and the stored results are unaffected.
- R3: The measurement accepted at index 0 (meas_valid_i high while meas_req_o is high) becomes the reference. Index 0 runs no search and has no trim code.
- R4: sel_o steps through 1 to NUM_SRC in increasing order. Exactly one measurement is accepted at each index.
- R5: When a measurement for source s ≥ 1 is accepted, err_o becomes meas_i − reference·2^REF_SHIFT as a signed two's-complement value of ERR_W bits, and it holds until the next accepted measurement.
- R6: The search sets each trim bit in turn, MSB first, one per cycle. The bit is kept when cmp_i is 1 in that cycle and cleared when it is 0. A comparator that reports 1 exactly when the trial code is at or below a target T therefore leaves the code at T clamped to 0..2^TRIM_W−1.
- R7: An accepted start resets every trim code to mid-scale before any source is searched.
- R8: done_o pulses high for exactly one cycle after the search of source NUM_SRC completes. busy_o is low in that cycle.
- R9: rd_code_o returns the stored code of source rd_idx_i for indices 1 to NUM_SRC, and returns 0 for index 0.
- R10: Bits [(s−1)·TRIM_W +: TRIM_W] of trim_o hold the code of source s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start calibration request |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| sel_o | output | IDX_W | Calibration index (0 = reference, s = MSB source s) |
| meas_req_o | output | 1 | Measurement wanted for the selected index |
| meas_i | input | MEAS_W | Digitised current measurement |
| meas_valid_i | input | 1 | meas_i valid strobe |
| err_o | output | ERR_W | Signed error of the current source |
| cmp_i | input | 1 | Comparator decision: 1 keeps the trial bit |
| trim_o | output | NUM_SRC·TRIM_W | Trim codes of all sources, packed |
| rd_idx_i | input | IDX_W | Read port index |
| rd_code_o | output | TRIM_W | Trim code at rd_idx_i |

## Verification
Two complete runs use different reference values and different per-source error patterns. The errors sweep both signs, so err_o is checked for sign handling and for the scaling of the reference. Each pattern places some targets beyond the code range at both ends, which shows whether the search clamps to all-ones and all-zeros rather than wrapping. Targets in between confirm the bit-by-bit decisions. A start pulse in the middle of the first run tells apart a sequencer that restarts from one that ignores the pulse. The trim codes read right after the second start separate the mid-scale reset from codes left over from the first run.

// File: rtl/dac_trim_cal_pkg.sv
package dac_trim_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_SAR  = 2'd2
  } cal_st_e;
endpackage

// File: rtl/dac_trim_cal_seq.sv
module dac_trim_cal_seq
  import dac_trim_cal_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             meas_valid_i,
  input  logic             sar_last_i,
  output cal_st_e          st_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             clear_o,
  output logic             ref_we_o,
  output logic             err_we_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_SRC);

  cal_st_e          st_q;
  logic [IDX_W-1:0] sel_q;
  logic             done_q;

  assign clear_o  = (st_q == ST_IDLE) && start_i;
  assign ref_we_o = (st_q == ST_MEAS) && meas_valid_i && (sel_q == '0);
  assign err_we_o = (st_q == ST_MEAS) && meas_valid_i && (sel_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_MEAS;
          sel_q <= '0;
        end
        ST_MEAS: begin
          if (ref_we_o) sel_q <= IDX_W'(1);
          else if (err_we_o) st_q <= ST_SAR;
        end
        ST_SAR: if (sar_last_i) begin
          if (sel_q == LastIdx) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            sel_q <= sel_q + IDX_W'(1);
            st_q  <= ST_MEAS;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign sel_o  = sel_q;
  assign done_o = done_q;
endmodule

// File: rtl/dac_trim_cal_err.sv
module dac_trim_cal_err #(
  parameter int MEAS_W    = 12,
  parameter int REF_SHIFT = 2,
  parameter int ERR_W     = MEAS_W + REF_SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_we_i,
  input  logic              err_we_i,
  input  logic [MEAS_W-1:0] meas_i,
  output logic [ERR_W-1:0]  err_o
);
  logic [MEAS_W-1:0] ref_q;
  logic [ERR_W-1:0]  ref_sc;
  logic [ERR_W-1:0]  err_q;

  // unit MSB current = LSB current scaled by 2^REF_SHIFT
  assign ref_sc = ERR_W'(ref_q) << REF_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      err_q <= '0;
    end else begin
      if (ref_we_i) ref_q <= meas_i;
      if (err_we_i) err_q <= ERR_W'(meas_i) - ref_sc;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/dac_trim_cal_sar.sv
module dac_trim_cal_sar #(
  parameter int TRIM_W = 6,
  parameter int BIT_W  = $clog2(TRIM_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              cmp_i,
  input  logic [TRIM_W-1:0] code_i,
  output logic [TRIM_W-1:0] code_o,
  output logic              we_o,
  output logic              last_o
);
  logic [BIT_W-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bit_q <= '0;
    else if (init_i)                   bit_q <= BIT_W'(TRIM_W - 1);
    else if (step_i && bit_q != '0)    bit_q <= bit_q - BIT_W'(1);
  end

  // resolve current bit, arm the next lower one
  always_comb begin
    code_o = code_i;
    code_o[bit_q] = cmp_i;
    if (bit_q != '0) code_o[bit_q - BIT_W'(1)] = 1'b1;
  end

  assign we_o   = step_i;
  assign last_o = step_i && (bit_q == '0);
endmodule

// File: rtl/dac_trim_cal_bank.sv
module dac_trim_cal_bank #(
  parameter int NUM_SRC = 63,
  parameter int TRIM_W  = 6,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          wsel_i,
  input  logic [TRIM_W-1:0]         wdata_i,
  output logic [TRIM_W-1:0]         cur_o,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [TRIM_W-1:0]         rd_code_o,
  output logic [NUM_SRC*TRIM_W-1:0] trim_o
);
  localparam logic [TRIM_W-1:0] Mid = TRIM_W'(1) << (TRIM_W - 1);

  logic [TRIM_W-1:0] code_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [TRIM_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    code_q <= Mid;
      else if (clear_i)                               code_q <= Mid;
      else if (we_i && wsel_i == IDX_W'(g + 1))       code_q <= wdata_i;
    end
    assign code_arr[g] = code_q;
    assign trim_o[g*TRIM_W +: TRIM_W] = code_q;
  end

  always_comb begin
    cur_o     = Mid;
    rd_code_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (wsel_i   == IDX_W'(i + 1)) cur_o     = code_arr[i];
      if (rd_idx_i == IDX_W'(i + 1)) rd_code_o = code_arr[i];
    end
  end
endmodule

// File: rtl/dac_trim_cal.sv
module dac_trim_cal
  import dac_trim_cal_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int TRIM_W    = 6,
  parameter int MEAS_W    = 12,
  parameter int REF_SHIFT = 2,
  parameter int IDX_W     = $clog2(NUM_SRC + 1),
  parameter int ERR_W     = MEAS_W + REF_SHIFT + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [IDX_W-1:0]          sel_o,
  output logic                      meas_req_o,
  input  logic [MEAS_W-1:0]         meas_i,
  input  logic                      meas_valid_i,
  output logic [ERR_W-1:0]          err_o,
  input  logic                      cmp_i,
  output logic [NUM_SRC*TRIM_W-1:0] trim_o,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [TRIM_W-1:0]         rd_code_o
);
  cal_st_e           st;
  logic              clear, ref_we, err_we, sar_last, sar_we;
  logic [TRIM_W-1:0] cur_code, nxt_code;

  dac_trim_cal_seq #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .meas_valid_i,
    .sar_last_i(sar_last), .st_o(st), .sel_o, .clear_o(clear),
    .ref_we_o(ref_we), .err_we_o(err_we), .done_o
  );

  dac_trim_cal_err #(.MEAS_W(MEAS_W), .REF_SHIFT(REF_SHIFT), .ERR_W(ERR_W)) u_err (
    .clk_i, .rst_ni, .ref_we_i(ref_we), .err_we_i(err_we), .meas_i, .err_o
  );

  dac_trim_cal_sar #(.TRIM_W(TRIM_W)) u_sar (
    .clk_i, .rst_ni, .init_i(err_we), .step_i(st == ST_SAR), .cmp_i,
    .code_i(cur_code), .code_o(nxt_code), .we_o(sar_we), .last_o(sar_last)
  );

  dac_trim_cal_bank #(.NUM_SRC(NUM_SRC), .TRIM_W(TRIM_W), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni, .clear_i(clear), .we_i(sar_we), .wsel_i(sel_o),
    .wdata_i(nxt_code), .cur_o(cur_code), .rd_idx_i, .rd_code_o, .trim_o
  );

  assign busy_o     = (st != ST_IDLE);
  assign meas_req_o = (st == ST_MEAS);
endmodule

// File: rtl/dac_trim_cal_chk.sv
module dac_trim_cal_chk #(
  parameter int NUM_SRC = 63,
  parameter int IDX_W   = 6,
  parameter int ERR_W   = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] sel_o,
  input logic             meas_req_o,
  input logic             meas_valid_i,
  input logic [ERR_W-1:0] err_o
);
  p_idle_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !meas_req_o);

  p_start_at_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sel_o == '0);

  p_sel_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (sel_o == $past(sel_o) || sel_o == $past(sel_o) + IDX_W'(1)));

  p_err_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_valid_i |=> $stable(err_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && $past(sel_o) == IDX_W'(NUM_SRC)));
endmodule

bind dac_trim_cal dac_trim_cal_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ERR_W(ERR_W)) u_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .sel_o, .meas_req_o, .meas_valid_i, .err_o
);

// File: tb/dac_trim_cal_test.sv
module dac_trim_cal_test;
  localparam int NS = 63, TW = 6, MW = 12, RS = 2;
  localparam int IW = 6, EW = MW + RS + 1;

  logic          clk = 0, rst_n = 0, start = 0, meas_valid = 0, cmp;
  logic          busy, done, meas_req;
  logic [IW-1:0] sel, rd_idx = '0;
  logic [MW-1:0] meas = '0;
  logic [EW-1:0] err;
  logic [NS*TW-1:0] trim;
  logic [TW-1:0] rd_code, cur_code;

  int n_chk = 0, n_bad = 0, pat = 0, ref_v = 100, wait_cnt = 0;
  int n_meas = 0, order_bad = 0, last_sel = -1, chk_sel = -1;

  always #2.5 clk = ~clk;

  dac_trim_cal uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .sel_o(sel), .meas_req_o(meas_req), .meas_i(meas), .meas_valid_i(meas_valid),
    .err_o(err), .cmp_i(cmp), .trim_o(trim), .rd_idx_i(rd_idx), .rd_code_o(rd_code)
  );

  function automatic int delta(int p, int s);
    return (p == 0) ? ((s * 37) % 81) - 40 : 40 - ((s * 53) % 81);
  endfunction

  function automatic int tgt(int p, int s);
    int t = (1 << (TW - 1)) - delta(p, s);
    if (t < 0) t = 0;
    if (t > (1 << TW) - 1) t = (1 << TW) - 1;
    return t;
  endfunction

  assign cur_code = (sel != '0) ? trim[(int'(sel) - 1) * TW +: TW] : '0;
  assign cmp = int'(cur_code) <= tgt(pat, int'(sel));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // measurement responder and error monitor, off the active edge
  always @(negedge clk) begin
    if (chk_sel > 0) check("R5 err", int'($signed(err)), delta(pat, chk_sel));
    chk_sel = -1;
    if (meas_valid) chk_sel = last_sel;
    meas_valid <= 1'b0;
    if (meas_req && !meas_valid) begin
      wait_cnt++;
      if (wait_cnt == 2) begin
        wait_cnt = 0;
        if (int'(sel) != last_sel + 1) order_bad++;
        last_sel = int'(sel);
        n_meas++;
        meas <= (sel == '0) ? MW'(ref_v) : MW'(ref_v * (1 << RS) + delta(pat, int'(sel)));
        meas_valid <= 1'b1;
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 sel", sel, 0);
    for (int s = 1; s <= NS; s += 31)
      check("R1 code", trim[(s - 1) * TW +: TW], 32);
  endtask

  task automatic t_run(int p, int r, bit poke);
    pat = p; ref_v = r; n_meas = 0; order_bad = 0; last_sel = -1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R2 busy", busy, 1);
    check("R2 sel0", sel, 0);
    check("R2 req", meas_req, 1);
    rd_idx = IW'(NS);
    #1 check("R7 midscale", rd_code, 32);
    if (poke) begin
      while (sel != IW'(20)) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
      check("R2 start ignored busy", busy, 1);
      check("R2 start ignored sel", (sel >= IW'(20)) ? 1 : 0, 1);
    end
    while (!done) @(negedge clk);
    check("R8 busy low", busy, 0);
    @(negedge clk);
    check("R8 single pulse", done, 0);
    check("R4 count", n_meas, NS + 1);
    check("R4 order", order_bad, 0);
    check("R3 ref no code", last_sel, NS);
    for (int s = 1; s <= NS; s++) begin
      rd_idx = IW'(s);
      #1 check("R6 code via R9", rd_code, tgt(p, s));
      check("R10 trim bus", trim[(s - 1) * TW +: TW], tgt(p, s));
    end
    rd_idx = '0;
    #1 check("R9 idx0", rd_code, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_run(0, 100, 1'b1);
    t_run(1, 200, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule